// File: doc/BRIEF.md
# Arithmetic Unit with Sticky Condition Flags

This block is the arithmetic and logic stage of a small 8-bit processor core. It has a combinational datapath that adds two unsigned operands, compares them for equality or ordering, or shifts or rotates the first operand one place to the left. A four-bit condition register sits behind the datapath and holds a zero flag, a carry-out flag, an equality flag and an ordering flag.

Each operation owns a fixed subset of the flags. A clock edge with the update enable high rewrites only the flags that the selected operation owns. Every other flag keeps its value, so a later instruction can test a flag that an earlier operation set. Branch decisions use the flag outputs outside this block.

The datapath width is a parameter (`W`, default 8). The operation select is a 3-bit code. Codes 5 to 7 are reserved and act as no-operations.

Top module: `alu_status_unit`

## Requirements
- R1: With op_sel = 3'd0 (add), result equals (opnd_a + opnd_b) modulo 2^W in the same cycle.
- R2: An add with upd_en high sets flag_ovf to the carry out of the top bit and flag_zero to (sum modulo 2^W == 0) at the next rising clock edge.
- R3: With op_sel = 3'd1 (equality compare), result is 0 and, with upd_en high, flag_eq becomes (opnd_a == opnd_b) at the next edge.
- R4: With op_sel = 3'd2 (ordering compare), result is 0 and, with upd_en high, flag_lt becomes (opnd_a < opnd_b) at the next edge, compared as unsigned values.
- R5: With op_sel = 3'd3 (shift left), result is opnd_a shifted left by one place. Bit 0 is filled with 0, the top bit is dropped, and opnd_b is ignored.
- R6: With op_sel = 3'd4 (rotate left), result is opnd_a shifted left by one place, with the top bit moved into bit 0.
- R7: A flag that the selected operation does not own keeps its value across an update. Shift and rotate own no flag. Add owns only zero and carry-out. Each compare owns only its own flag.
- R8: While upd_en is low, no flag changes at a clock edge.
- R9: A rising edge with rst high clears all four flags, whatever the other inputs are. The result output stays combinational while rst is high.
- R10: Reserved codes 3'd5, 3'd6 and 3'd7 give a result of 0 and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_sel | input | 3 | Operation code (0 add, 1 equality compare, 2 ordering compare, 3 shift left, 4 rotate left, 5-7 reserved) |
| opnd_a | input | W | First operand, and the only operand of shift and rotate |
| opnd_b | input | W | Second operand |
| upd_en | input | 1 | Lets the owned flags load at the next edge |
| result | output | W | Combinational operation result |
| flag_zero | output | 1 | Registered zero flag from the last add |
| flag_ovf | output | 1 | Registered carry-out flag from the last add |
| flag_eq | output | 1 | Registered equality flag from the last equality compare |
| flag_lt | output | 1 | Registered ordering flag from the last ordering compare |

## Verification
The bench builds the unit with W = 8, the width the processor uses. At that width the cases that matter are reachable with a few chosen operands: an add that wraps exactly to zero, an add that carries without giving zero, a sum that only crosses into the top bit, operands at 0x00 and 0xFF on both sides of the ordering compare, and shift and rotate patterns with the top bit set. The bench models the flag state one update at a time. Long sequences therefore show whether a flag that the current operation does not own keeps the value set several instructions earlier.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_CMPE = 3'd1,
        OP_CMPL = 3'd2,
        OP_SHL  = 3'd3,
        OP_ROL  = 3'd4,
        OP_RSV5 = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } alu_op_e;

    localparam int NFLAGS = 4;

    typedef struct packed {
        logic zero;
        logic ovf;
        logic eq;
        logic lt;
    } flags_t;

    localparam flags_t FLAGS_CLEAR = '0;

    // Which flags an operation is allowed to rewrite.
    function automatic flags_t own_mask(alu_op_e op);
        flags_t m;
        m = FLAGS_CLEAR;
        case (op)
            OP_ADD:  begin m.zero = 1'b1; m.ovf = 1'b1; end
            OP_CMPE: m.eq = 1'b1;
            OP_CMPL: m.lt = 1'b1;
            default: m = FLAGS_CLEAR;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
    import alu_flags_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res,
    output flags_t         cand,
    output flags_t         mask
);
    localparam int EXT = W + 1;

    logic [EXT-1:0] sum_ext;
    logic [W-1:0]   shl_v;
    logic [W-1:0]   rol_v;

    assign sum_ext = {1'b0, a} + {1'b0, b};
    assign shl_v   = {a[W-2:0], 1'b0};
    assign rol_v   = {a[W-2:0], a[W-1]};

    always_comb begin
        case (op)
            OP_ADD:  res = sum_ext[W-1:0];
            OP_SHL:  res = shl_v;
            OP_ROL:  res = rol_v;
            default: res = '0;
        endcase
    end

    always_comb begin
        cand      = FLAGS_CLEAR;
        cand.zero = (sum_ext[W-1:0] == '0);
        cand.ovf  = sum_ext[W];
        cand.eq   = (a == b);
        cand.lt   = (a < b);
    end

    assign mask = own_mask(op);

endmodule

// File: rtl/flag_register.sv
module flag_register
    import alu_flags_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  flags_t mask,
    input  flags_t cand,
    output flags_t q
);
    logic [NFLAGS-1:0] mask_bits;
    logic [NFLAGS-1:0] cand_bits;
    logic [NFLAGS-1:0] q_bits;

    assign mask_bits = mask;
    assign cand_bits = cand;

    for (genvar i = 0; i < NFLAGS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q_bits[i] <= 1'b0;
            else if (en && mask_bits[i])
                q_bits[i] <= cand_bits[i];
        end
    end

    assign q = flags_t'(q_bits);

endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
    import alu_flags_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   op_sel,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         upd_en,
    output logic [W-1:0] result,
    output logic         flag_zero,
    output logic         flag_ovf,
    output logic         flag_eq,
    output logic         flag_lt
);
    alu_op_e op;
    flags_t  cand;
    flags_t  mask;
    flags_t  held;

    assign op = alu_op_e'(op_sel);

    alu_datapath #(.W(W)) u_dp (
        .op   (op),
        .a    (opnd_a),
        .b    (opnd_b),
        .res  (result),
        .cand (cand),
        .mask (mask)
    );

    flag_register u_flags (
        .clk  (clk),
        .rst  (rst),
        .en   (upd_en),
        .mask (mask),
        .cand (cand),
        .q    (held)
    );

    assign flag_zero = held.zero;
    assign flag_ovf  = held.ovf;
    assign flag_eq   = held.eq;
    assign flag_lt   = held.lt;

endmodule

// File: rtl/alu_status_chk.sv
module alu_status_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [2:0]   op_sel,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic         upd_en,
    input logic [W-1:0] result,
    input logic         flag_zero,
    input logic         flag_ovf,
    input logic         flag_eq,
    input logic         flag_lt
);
    logic [3:0] fl;
    logic [W:0] ref_sum;
    assign fl      = {flag_zero, flag_ovf, flag_eq, flag_lt};
    assign ref_sum = {1'b0, opnd_a} + {1'b0, opnd_b};

    // R1
    p_add_sum_r1: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'd0) |-> (result == ref_sum[W-1:0]));

    // R2
    p_add_flags_r2: assert property (@(posedge clk) disable iff (rst)
        (upd_en && op_sel == 3'd0) |=>
            (flag_ovf == $past(ref_sum[W]) && flag_zero == $past(ref_sum[W-1:0] == '0)));

    // R3
    p_eq_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (upd_en && op_sel == 3'd1) |=> (flag_eq == $past(opnd_a == opnd_b)));

    // R4
    p_lt_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (upd_en && op_sel == 3'd2) |=> (flag_lt == $past(opnd_a < opnd_b)));

    // R3, R4
    p_cmp_no_result_r4: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'd1 || op_sel == 3'd2) |-> (result == '0));

    // R7
    p_shift_keeps_flags_r7: assert property (@(posedge clk) disable iff (rst)
        (upd_en && (op_sel == 3'd3 || op_sel == 3'd4)) |=> $stable(fl));

    // R8
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!upd_en) |=> $stable(fl));

    // R9
    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (fl == 4'b0000));

    // R10
    p_reserved_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (op_sel >= 3'd5) |=> ($past(result) == '0 && (!$past(upd_en) || $stable(fl))));

endmodule

bind alu_status_unit alu_status_chk #(.W(W)) u_chk (.*);

// File: tb/sim_alu_status_unit.sv
`timescale 1ns/1ps
module sim_alu_status_unit;
    localparam int  W    = 8;
    localparam real HALF = 2.5;
    localparam int  NV   = 20;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   op_sel = 3'd0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic         upd_en = 1'b0;
    logic [W-1:0] result;
    logic         flag_zero, flag_ovf, flag_eq, flag_lt;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    // expected flag state: {zero, ovf, eq, lt}
    logic [3:0] mdl = 4'b0000;

    always #(HALF) clk = ~clk;

    alu_status_unit #(.W(W)) u0 (
        .clk(clk), .rst(rst), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .upd_en(upd_en), .result(result), .flag_zero(flag_zero), .flag_ovf(flag_ovf),
        .flag_eq(flag_eq), .flag_lt(flag_lt)
    );

    // {op, a, b, upd, expected result}
    localparam logic [27:0] VEC [NV] = '{
        {3'd0, 8'h12, 8'h34, 1'b1, 8'h46},
        {3'd0, 8'hFF, 8'h01, 1'b1, 8'h00},
        {3'd0, 8'h80, 8'h80, 1'b1, 8'h00},
        {3'd0, 8'h7F, 8'h01, 1'b1, 8'h80},
        {3'd1, 8'h5A, 8'h5A, 1'b1, 8'h00},
        {3'd1, 8'h5A, 8'h5B, 1'b1, 8'h00},
        {3'd2, 8'h03, 8'h04, 1'b1, 8'h00},
        {3'd2, 8'h04, 8'h03, 1'b1, 8'h00},
        {3'd2, 8'hFF, 8'h00, 1'b1, 8'h00},
        {3'd2, 8'h00, 8'hFF, 1'b1, 8'h00},
        {3'd3, 8'h81, 8'hFF, 1'b1, 8'h02},
        {3'd3, 8'h40, 8'h00, 1'b1, 8'h80},
        {3'd4, 8'h81, 8'h00, 1'b1, 8'h03},
        {3'd4, 8'h7E, 8'hAA, 1'b1, 8'hFC},
        {3'd0, 8'hFF, 8'hFF, 1'b0, 8'hFE},
        {3'd1, 8'h11, 8'h11, 1'b0, 8'h00},
        {3'd5, 8'h33, 8'h44, 1'b1, 8'h00},
        {3'd7, 8'hFF, 8'hFF, 1'b1, 8'h00},
        {3'd0, 8'hC8, 8'h64, 1'b1, 8'h2C},
        {3'd1, 8'h00, 8'h00, 1'b1, 8'h00}
    };

    function automatic string res_tag(logic [2:0] op);
        case (op)
            3'd0: return "R1";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R10";
        endcase
    endfunction

    function automatic string flag_tag(logic [2:0] op, logic upd);
        if (!upd) return "R8";
        case (op)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3, 3'd4: return "R7";
            default: return "R10";
        endcase
    endfunction

    // Flag model built from the requirements, applied at each edge
    function automatic logic [3:0] next_flags(logic [3:0] cur, logic r, logic [2:0] op,
                                              logic [7:0] a, logic [7:0] b, logic upd);
        logic [3:0] n;
        logic [8:0] s;
        n = cur;
        s = {1'b0, a} + {1'b0, b};
        if (r) n = 4'b0000;
        else if (upd) begin
            case (op)
                3'd0: begin n[3] = (s[7:0] == 8'h00); n[2] = s[8]; end
                3'd1: n[1] = (a == b);
                3'd2: n[0] = (a < b);
                default: n = cur;
            endcase
        end
        return n;
    endfunction

    task automatic check_res(string tag, logic [7:0] exp);
        vectors++;
        if (result !== exp) begin
            misses++;
            $display("FAIL %s result got %h expected %h", tag, result, exp);
        end
    endtask

    task automatic check_flags(string tag, logic [3:0] exp);
        logic [3:0] got;
        got = {flag_zero, flag_ovf, flag_eq, flag_lt};
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s flags got %b expected %b", tag, got, exp);
        end
    endtask

    // drive at negedge, settle, then take the next rising edge
    task automatic step(logic r, logic [2:0] op, logic [7:0] a, logic [7:0] b, logic upd);
        @(negedge clk);
        rst = r; op_sel = op; opnd_a = a; opnd_b = b; upd_en = upd;
        #1;
    endtask

    task automatic edge_and_model();
        @(posedge clk);
        mdl = next_flags(mdl, rst, op_sel, opnd_a, opnd_b, upd_en);
        #1;
    endtask

    initial begin
        #(200000 * 2 * HALF);
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        // reset state (R9)
        step(1'b1, 3'd0, 8'h00, 8'h00, 1'b0);
        edge_and_model();
        check_flags("R9", 4'b0000);
        edge_and_model();

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [2:0] vo; logic [7:0] va, vb, ve; logic vu;
            {vo, va, vb, vu, ve} = VEC[i];
            step(1'b0, vo, va, vb, vu);
            check_res(res_tag(vo), ve);
            edge_and_model();
            check_flags(flag_tag(vo, vu), mdl);
        end

        // R7: add leaves eq/lt; set eq and lt first
        step(1'b0, 3'd1, 8'h09, 8'h09, 1'b1); edge_and_model();
        step(1'b0, 3'd2, 8'h01, 8'h02, 1'b1); edge_and_model();
        step(1'b0, 3'd0, 8'h01, 8'h01, 1'b1); edge_and_model();
        check_flags("R7", 4'b0011);
        // R7: compare-equal clears eq only, lt kept
        step(1'b0, 3'd1, 8'h01, 8'h02, 1'b1); edge_and_model();
        check_flags("R7", 4'b0001);
        // R2: wrap to zero sets both add flags
        step(1'b0, 3'd0, 8'h01, 8'hFF, 1'b1); edge_and_model();
        check_flags("R2", 4'b1101);
        // R5: opnd_b has no effect on the shift
        step(1'b0, 3'd3, 8'hC3, 8'h00, 1'b0);
        check_res("R5", 8'h86);
        step(1'b0, 3'd3, 8'hC3, 8'h5A, 1'b0);
        check_res("R5", 8'h86);
        // R6: all-ones rotates to itself
        step(1'b0, 3'd4, 8'hFF, 8'h00, 1'b0);
        check_res("R6", 8'hFF);
        // R8: a held-off update leaves flags
        step(1'b0, 3'd2, 8'h05, 8'h01, 1'b0); edge_and_model();
        check_flags("R8", 4'b1101);
        // R9: reset wins over an update; result still combinational
        step(1'b1, 3'd0, 8'h20, 8'h22, 1'b1);
        check_res("R9", 8'h42);
        edge_and_model();
        check_flags("R9", 4'b0000);
        // R10: reserved code 6
        step(1'b0, 3'd6, 8'hAA, 8'hAA, 1'b1);
        check_res("R10", 8'h00);
        edge_and_model();
        check_flags("R10", 4'b0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule